// File: doc/BRIEF.md
# Condition Register File with Same-Cycle Forwarding

This block holds a processor's condition register as one 32-bit word split into eight 4-bit nibbles. A single write port updates any subset of nibbles in one cycle, chosen by an 8-bit mask. The read port always returns the full word.

A write that is present in the current cycle is merged into the read value nibble by nibble. A reader in that cycle therefore sees the value the register will hold after the next clock edge, without waiting for the edge. Nibbles outside the mask are read from the stored word. The read path is combinational from the write inputs. The stored word changes only on a rising clock edge.

At most one write can happen per cycle. A synchronous reset clears the word.

Top module: `cond_reg_file`

## Requirements
- R1: After a synchronous reset, with the write strobe low, `rd_data` reads 32'h0.
- R2: At a rising edge with `wr_en` high and mask bit i set, nibble i (bits 4i+3..4i) takes `wr_data[4i+3:4i]`.
- R3: At a rising edge with `wr_en` high, every nibble whose mask bit is clear keeps its value.
- R4: At a rising edge with `wr_en` low, the stored word does not change, whatever `wr_mask` and `wr_data` hold.
- R5: While `wr_en` is high, each nibble of `rd_data` whose mask bit is set equals the same nibble of `wr_data` in that same cycle.
- R6: While `wr_en` is high, each nibble of `rd_data` whose mask bit is clear equals the stored nibble.
- R7: While `wr_en` is low, `rd_data` equals the stored word, whatever `wr_mask` and `wr_data` hold.
- R8: If a write and a reset arrive at the same rising edge, the reset wins and the word becomes 32'h0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_mask | input | 8 | Nibble enables; bit i selects bits 4i+3..4i |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Stored word with the current write merged in |

## Verification
The bench drives the following mask patterns:
- An all-ones mask replaces the whole word, which shows that every nibble can be written.
- A single-nibble mask and a low-half mask show whether the enable of one nibble leaks into its neighbours.
- A zero mask with the strobe high, and a full mask with the strobe low, tell the strobe and the mask apart as the qualifiers of a write.

Each cycle the read output is checked twice: once while the write is still present, which exercises forwarding, and once on the following read, which shows what was stored. Random data and masks fill in the cases between these patterns. A write held during reset shows that the reset has priority.

// File: rtl/crf_pkg.sv
package crf_pkg;
   parameter int CRF_NIBBLE_W = 4;
   parameter int CRF_NUM_NIB  = 8;
   localparam int CRF_WORD_W  = CRF_NIBBLE_W * CRF_NUM_NIB;
   typedef logic [CRF_WORD_W-1:0] crf_word_t;
endpackage

// File: rtl/crf_mask_expand.sv
module crf_mask_expand #(
   parameter int NIBBLE_W = 4,
   parameter int NUM_NIB  = 8,
   localparam int WORD_W  = NIBBLE_W * NUM_NIB
) (
   input  logic [NUM_NIB-1:0] nib_mask,
   input  logic               strobe,
   output logic [WORD_W-1:0]  bit_mask
);
   for (genvar i = 0; i < NUM_NIB; i++) begin : g_nib
      assign bit_mask[i*NIBBLE_W +: NIBBLE_W] = {NIBBLE_W{nib_mask[i] & strobe}};
   end
endmodule

// File: rtl/crf_nibble_reg.sv
module crf_nibble_reg #(
   parameter int NIBBLE_W = 4
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                load,
   input  logic [NIBBLE_W-1:0] d,
   output logic [NIBBLE_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst)
         q <= '0;
      else if (load)
         q <= d;
   end
endmodule

// File: rtl/crf_fwd_mux.sv
module crf_fwd_mux #(
   parameter int NIBBLE_W = 4,
   parameter int NUM_NIB  = 8,
   parameter bit FORWARD  = 1'b1,
   localparam int WORD_W  = NIBBLE_W * NUM_NIB
) (
   input  logic [WORD_W-1:0] stored,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [WORD_W-1:0] bit_mask,
   output logic [WORD_W-1:0] rd_data
);
   if (FORWARD) begin : g_fwd
      for (genvar i = 0; i < NUM_NIB; i++) begin : g_nib
         localparam int LO = i * NIBBLE_W;
         assign rd_data[LO +: NIBBLE_W] = bit_mask[LO] ? wr_data[LO +: NIBBLE_W]
                                                       : stored[LO +: NIBBLE_W];
      end
   end else begin : g_nofwd
      logic [WORD_W-1:0] unused_mix;
      assign unused_mix = wr_data & bit_mask;
      assign rd_data    = stored;
   end
endmodule

// File: rtl/cond_reg_file.sv
module cond_reg_file #(
   parameter int NIBBLE_W = crf_pkg::CRF_NIBBLE_W,
   parameter int NUM_NIB  = crf_pkg::CRF_NUM_NIB,
   parameter bit FORWARD  = 1'b1,
   localparam int WORD_W  = NIBBLE_W * NUM_NIB
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               wr_en,
   input  logic [NUM_NIB-1:0] wr_mask,
   input  logic [WORD_W-1:0]  wr_data,
   output logic [WORD_W-1:0]  rd_data
);
   if (NIBBLE_W < 1) begin : g_bad_nw
      $error("cond_reg_file: NIBBLE_W must be at least 1");
   end
   if (NUM_NIB < 1) begin : g_bad_nn
      $error("cond_reg_file: NUM_NIB must be at least 1");
   end

   logic [WORD_W-1:0] bit_mask;
   logic [WORD_W-1:0] stored_q;

   crf_mask_expand #(.NIBBLE_W(NIBBLE_W), .NUM_NIB(NUM_NIB)) u_expand (
      .nib_mask (wr_mask),
      .strobe   (wr_en),
      .bit_mask (bit_mask)
   );

   for (genvar i = 0; i < NUM_NIB; i++) begin : g_store
      crf_nibble_reg #(.NIBBLE_W(NIBBLE_W)) u_nib (
         .clk  (clk),
         .rst  (rst),
         .load (bit_mask[i*NIBBLE_W]),
         .d    (wr_data[i*NIBBLE_W +: NIBBLE_W]),
         .q    (stored_q[i*NIBBLE_W +: NIBBLE_W])
      );
   end

   crf_fwd_mux #(.NIBBLE_W(NIBBLE_W), .NUM_NIB(NUM_NIB), .FORWARD(FORWARD)) u_fwd (
      .stored   (stored_q),
      .wr_data  (wr_data),
      .bit_mask (bit_mask),
      .rd_data  (rd_data)
   );
endmodule

// File: rtl/crf_chk.sv
module crf_chk #(
   parameter int NIBBLE_W = 4,
   parameter int NUM_NIB  = 8,
   localparam int WORD_W  = NIBBLE_W * NUM_NIB
) (
   input logic               clk,
   input logic               rst,
   input logic               wr_en,
   input logic [NUM_NIB-1:0] wr_mask,
   input logic [WORD_W-1:0]  wr_data,
   input logic [WORD_W-1:0]  rd_data,
   input logic [WORD_W-1:0]  stored
);
   logic [WORD_W-1:0] sel;
   always_comb begin
      for (int i = 0; i < WORD_W; i++) sel[i] = wr_mask[i / NIBBLE_W];
   end

   // R2
   masked_write_chk: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> ((stored & $past(sel)) == ($past(wr_data) & $past(sel))));
   // R3
   unmasked_keep_chk: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> ((stored & ~$past(sel)) == ($past(stored) & ~$past(sel))));
   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> (stored == $past(stored)));
   // R5
   forward_new_chk: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> (((rd_data ^ wr_data) & sel) == '0));
   // R6
   forward_old_chk: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> (((rd_data ^ stored) & ~sel) == '0));
   // R7
   idle_read_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_en |-> (rd_data == stored));
   // R8
   reset_wins_chk: assert property (@(posedge clk)
      rst |=> (stored == '0));
endmodule

bind cond_reg_file crf_chk #(.NIBBLE_W(NIBBLE_W), .NUM_NIB(NUM_NIB)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .wr_en   (wr_en),
   .wr_mask (wr_mask),
   .wr_data (wr_data),
   .rd_data (rd_data),
   .stored  (stored_q)
);

// File: tb/sim_cond_reg_file.sv
`timescale 1ns/1ps
module sim_cond_reg_file;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_mask = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;

   int          n_checks = 0;
   int          n_errors = 0;
   logic [31:0] model = '0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   cond_reg_file u0 (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_mask(wr_mask),
      .wr_data(wr_data), .rd_data(rd_data)
   );

   function automatic logic [31:0] expand(input logic [7:0] m);
      logic [31:0] r;
      for (int i = 0; i < 8; i++) r[i*4 +: 4] = {4{m[i]}};
      return r;
   endfunction

   function automatic logic [31:0] merge(input logic [31:0] old, input logic en,
                                         input logic [7:0] m, input logic [31:0] d);
      logic [31:0] e;
      e = en ? expand(m) : 32'h0;
      return (old & ~e) | (d & e);
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   // drive one cycle, check the forwarded read mid-cycle, then advance the model
   task automatic step(input logic en, input logic [7:0] m, input logic [31:0] d);
      logic [31:0] e;
      @(negedge clk);
      wr_en = en; wr_mask = m; wr_data = d;
      #1;
      e = expand(m);
      if (!en)
         check("R7", rd_data, model);
      else begin
         check("R5", rd_data & e, d & e);
         if (m != 8'hFF) check("R6", rd_data & ~e, model & ~e);
      end
      @(posedge clk);
      model = merge(model, en, m, d);
   endtask

   task automatic read_as(input string tag);
      @(negedge clk);
      wr_en = 1'b0; wr_mask = 8'h00; wr_data = 32'h0;
      #1;
      check(tag, rd_data, model);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_checks++; n_errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 1'b0;
      model = '0;
      read_as("R1");

      step(1'b1, 8'hFF, 32'hA5C3_961E);
      read_as("R2");
      step(1'b1, 8'h0F, 32'h1234_5678);
      read_as("R3");
      step(1'b1, 8'h10, 32'hFFFF_FFFF);
      read_as("R3");
      step(1'b0, 8'hFF, 32'h0000_0000);
      read_as("R4");
      step(1'b1, 8'h00, 32'hDEAD_BEEF);
      read_as("R3");
      step(1'b1, 8'h81, 32'h7000_0009);
      read_as("R2");

      // write held at the same edge as reset
      @(negedge clk);
      rst = 1'b1; wr_en = 1'b1; wr_mask = 8'hFF; wr_data = 32'hFFFF_FFFF;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0; wr_en = 1'b0;
      model = '0;
      read_as("R8");

      for (int k = 0; k < 400; k++) begin
         logic [7:0] m;
         m = 8'($urandom);
         if (k % 7 == 0) m = 8'hFF;
         if (k % 11 == 0) m = 8'h00;
         step(($urandom % 4) != 0, m, $urandom);
      end
      read_as("R4");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule